// File: doc/BRIEF.md
# Dual-Port Address Conflict Arbiter

This block sits beside a shared two-port memory and settles collisions between its left and right users. Each side presents an active-low select, an address, a write strobe and a one-cycle pulse that marks the end of its access. When both sides are selected on the same address, the block picks one winner and pulls the other side's active-low busy flag low. The flag stays low until the winner reports that its access is done. It also produces a gated write enable for each side, so that a losing side's write never reaches the array.

The winner is chosen by arrival order, sampled once per clock. If the addresses already agreed when the selects came in, the side that was selected earlier wins. If both sides were already selected when the addresses came to agree, the side whose address was in place first wins. A mode input turns the block into a slave for width expansion. In slave mode the arbiter is idle, and each side's write enable follows a busy flag supplied by an external master.

Top module: `dpa_conflict_arbiter`

## Requirements
- R1: A conflict exists only when both selects are low and both addresses are equal. Without a conflict, both busy outputs are high, and the two busy outputs are never low together.
- R2: If both sides are selected on equal addresses and one side was selected in the previous cycle while the other was not, the earlier side wins. The loser's busy output goes low in the same cycle the conflict appears.
- R3: If both sides were selected in the previous cycle and their addresses come to match now, the side whose address is unchanged from the previous cycle wins.
- R4: On a tie, the left side wins. A tie is either both selects arriving in the same cycle, or both addresses changing in the same cycle.
- R5: A side's write enable is low while that side's effective busy flag is low.
- R6: The loser's busy output stays low until the winner's done input is high at a clock edge. From the next cycle the former loser holds the grant: its busy output goes high and the former winner's busy output goes low, for as long as the conflict lasts. No new arbitration takes place.
- R7: When the conflict ends because a select rises or an address changes, both busy outputs go high in that same cycle and the grant is dropped.
- R8: With master_mode low, both busy outputs stay high. Each side's effective busy flag is then its busy input.
- R9: With master_mode high, the busy inputs have no effect.
- R10: After reset, with both sides deselected, both busy outputs are high and both write enables are low.
- R11: A write enable is high exactly when that side is selected, its write strobe is high and its effective busy flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_mode | input | 1 | 1: internal arbiter drives busy; 0: busy taken from inputs |
| l_sel_n | input | 1 | Left select, active low |
| l_addr | input | ADDR_W | Left address |
| l_wr | input | 1 | Left write strobe |
| l_done | input | 1 | Left access completed (one-cycle pulse) |
| l_busy_in_n | input | 1 | Left busy from external master (slave mode) |
| r_sel_n | input | 1 | Right select, active low |
| r_addr | input | ADDR_W | Right address |
| r_wr | input | 1 | Right write strobe |
| r_done | input | 1 | Right access completed (one-cycle pulse) |
| r_busy_in_n | input | 1 | Right busy from external master (slave mode) |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_en | output | 1 | Gated left write enable |
| r_wr_en | output | 1 | Gated right write enable |

## Verification
The bench builds the block with a 4-bit address. At that width every one of the 256 left/right address pairs can be swept under staggered selects, confirming that a busy flag appears on exact equality and nowhere else. The small width also keeps the directed sequences short. These cover each arrival-order case, both kinds of tie, the grant handover in both directions, conflict removal, and the slave-mode gating.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_L    = 0;
  localparam int unsigned SIDE_R    = 1;
endpackage

// File: rtl/dpa_reset_sync.sv
module dpa_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpa_side_track.sv
module dpa_side_track #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              active_q,
  output logic              addr_held
);
  logic              act_q, act_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign active = ~sel_n;

  always_comb begin
    act_d  = active;
    addr_d = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
    end
  end

  assign active_q  = act_q;
  assign addr_held = (addr == addr_q);
endmodule

// File: rtl/dpa_grant_fsm.sv
module dpa_grant_fsm
  import dpa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 conflict,
  input  logic [NUM_SIDES-1:0] act_q,
  input  logic [NUM_SIDES-1:0] addr_held,
  input  logic [NUM_SIDES-1:0] done,
  output logic [NUM_SIDES-1:0] busy_n
);
  owner_e owner_q, owner_d, cur;
  logic   fresh_right;

  always_comb begin
    if (act_q[SIDE_L] && act_q[SIDE_R])
      fresh_right = addr_held[SIDE_R] && !addr_held[SIDE_L];
    else
      fresh_right = act_q[SIDE_R] && !act_q[SIDE_L];
    if (owner_q != OWN_NONE) cur = owner_q;
    else                     cur = fresh_right ? OWN_RIGHT : OWN_LEFT;
  end

  always_comb begin
    busy_n[SIDE_L] = !(en && conflict && cur == OWN_RIGHT);
    busy_n[SIDE_R] = !(en && conflict && cur == OWN_LEFT);
  end

  always_comb begin
    if (!en || !conflict)                     owner_d = OWN_NONE;
    else if (cur == OWN_LEFT  && done[SIDE_L]) owner_d = OWN_RIGHT;
    else if (cur == OWN_RIGHT && done[SIDE_R]) owner_d = OWN_LEFT;
    else                                      owner_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assert_busy_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n != 2'b00);

  assert_idle_busy_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |-> busy_n == 2'b11);

  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && conflict && !busy_n[SIDE_R] && !done[SIDE_L])
      |=> (!conflict || !en || !busy_n[SIDE_R]));

  assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && conflict && !busy_n[SIDE_R] && done[SIDE_L])
      |=> (!conflict || !en || busy_n[SIDE_R]));

  assert_tie_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && conflict && owner_q == OWN_NONE && !act_q[SIDE_L] && !act_q[SIDE_R])
      |-> busy_n[SIDE_L]);
endmodule

// File: rtl/dpa_conflict_arbiter.sv
module dpa_conflict_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_done,
  input  logic              l_busy_in_n,
  input  logic              r_sel_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_done,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);
  logic                 rst_sync_n;
  logic [NUM_SIDES-1:0] sel_n_v, act_v, act_q_v, held_v, done_v, arb_busy_n;
  logic [NUM_SIDES-1:0] busy_in_v, wr_v, busy_eff_v, wr_en_v;
  logic [ADDR_W-1:0]    addr_v [NUM_SIDES];
  logic                 conflict;

  dpa_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign sel_n_v   = {r_sel_n, l_sel_n};
  assign done_v    = {r_done, l_done};
  assign busy_in_v = {r_busy_in_n, l_busy_in_n};
  assign wr_v      = {r_wr, l_wr};
  assign addr_v[SIDE_L] = l_addr;
  assign addr_v[SIDE_R] = r_addr;

  for (genvar gs = 0; gs < NUM_SIDES; gs++) begin : g_side
    dpa_side_track #(.ADDR_W(ADDR_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sel_n     (sel_n_v[gs]),
      .addr      (addr_v[gs]),
      .active    (act_v[gs]),
      .active_q  (act_q_v[gs]),
      .addr_held (held_v[gs])
    );
    assign busy_eff_v[gs] = master_mode ? arb_busy_n[gs] : busy_in_v[gs];
    assign wr_en_v[gs]    = act_v[gs] && wr_v[gs] && busy_eff_v[gs];
  end

  assign conflict = act_v[SIDE_L] && act_v[SIDE_R] &&
                    (addr_v[SIDE_L] == addr_v[SIDE_R]);

  dpa_grant_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (master_mode),
    .conflict  (conflict),
    .act_q     (act_q_v),
    .addr_held (held_v),
    .done      (done_v),
    .busy_n    (arb_busy_n)
  );

  assign l_busy_n = arb_busy_n[SIDE_L];
  assign r_busy_n = arb_busy_n[SIDE_R];
  assign l_wr_en  = wr_en_v[SIDE_L];
  assign r_wr_en  = wr_en_v[SIDE_R];

  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !master_mode |-> (l_busy_n && r_busy_n));

  assert_write_gate_l_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    l_wr_en |-> (master_mode ? l_busy_n : l_busy_in_n));

  assert_write_gate_r_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    r_wr_en |-> (master_mode ? r_busy_n : r_busy_in_n));

  assert_wr_needs_sel_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (l_wr_en |-> (!l_sel_n && l_wr)) and (r_wr_en |-> (!r_sel_n && r_wr)));
endmodule

// File: tb/dpa_conflict_arbiter_test.sv
module dpa_conflict_arbiter_test;
  localparam int unsigned AW = 4;

  logic clk = 1'b0;
  logic rst_n, master_mode;
  logic l_sel_n, l_wr, l_done, l_busy_in_n;
  logic r_sel_n, r_wr, r_done, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_n, r_busy_n, l_wr_en, r_wr_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dpa_conflict_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_sel_n(l_sel_n), .l_addr(l_addr), .l_wr(l_wr), .l_done(l_done),
    .l_busy_in_n(l_busy_in_n),
    .r_sel_n(r_sel_n), .r_addr(r_addr), .r_wr(r_wr), .r_done(r_done),
    .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // expected order: {l_busy_n, r_busy_n, l_wr_en, r_wr_en}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    #1;
    act = {l_busy_n, r_busy_n, l_wr_en, r_wr_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    l_sel_n = 1'b1; r_sel_n = 1'b1; l_wr = 1'b0; r_wr = 1'b0;
    l_done = 1'b0; r_done = 1'b0; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    l_addr = '0; r_addr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    master_mode = 1'b1;
    rst_n = 1'b0;
    repeat (3) cyc();
    chk("R10 in reset", 4'b1100);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R10 after reset", 4'b1100);

    // R1: exhaustive address sweep, left selected first, right writes
    for (int la = 0; la < (1 << AW); la++) begin
      for (int ra = 0; ra < (1 << AW); ra++) begin
        l_sel_n = 1'b0; l_addr = AW'(la);
        cyc();
        r_sel_n = 1'b0; r_addr = AW'(ra); r_wr = 1'b1;
        chk("R1 sweep", (la == ra) ? 4'b1000 : 4'b1101);
        idle();
        cyc();
      end
    end

    // R2: right selected first on equal addresses
    r_sel_n = 1'b0; r_addr = 4'h7; cyc();
    l_sel_n = 1'b0; l_addr = 4'h7; l_wr = 1'b1;
    chk("R2 right first, left busy, left write blocked R5", 4'b0100);
    idle(); cyc();

    // R3: addresses come to match, right address moves
    l_sel_n = 1'b0; r_sel_n = 1'b0; l_addr = 4'h2; r_addr = 4'h3; cyc();
    r_addr = 4'h2;
    chk("R3 left address held", 4'b1000);
    idle(); cyc();
    l_sel_n = 1'b0; r_sel_n = 1'b0; l_addr = 4'h9; r_addr = 4'hA; cyc();
    l_addr = 4'hA;
    chk("R3 right address held", 4'b0100);
    idle(); cyc();

    // R4: ties
    l_sel_n = 1'b0; r_sel_n = 1'b0; l_addr = 4'h4; r_addr = 4'h4;
    chk("R4 simultaneous selects", 4'b1000);
    idle(); cyc();
    l_sel_n = 1'b0; r_sel_n = 1'b0; l_addr = 4'h1; r_addr = 4'h2; cyc();
    l_addr = 4'hC; r_addr = 4'hC;
    chk("R4 simultaneous address change", 4'b1000);
    idle(); cyc();

    // R6 / R7 / R5 / R11: hold, handover, release
    l_sel_n = 1'b0; l_addr = 4'h5; cyc();
    r_sel_n = 1'b0; r_addr = 4'h5; r_wr = 1'b1;
    chk("R6 conflict arises", 4'b1000);
    cyc();
    chk("R6 held without done", 4'b1000);
    r_done = 1'b1; cyc(); r_done = 1'b0;
    chk("R6 loser done ignored", 4'b1000);
    l_done = 1'b1;
    chk("R6 done cycle still held", 4'b1000);
    cyc(); l_done = 1'b0;
    chk("R6 handover to right", 4'b0101);
    cyc();
    chk("R6 right holds", 4'b0101);
    r_done = 1'b1; cyc(); r_done = 1'b0;
    chk("R6 handover back to left", 4'b1000);
    l_sel_n = 1'b1;
    chk("R7 select release ends conflict", 4'b1101);
    cyc();
    l_sel_n = 1'b0; l_addr = 4'h5;
    chk("R2 right now earlier", 4'b0101);
    l_addr = 4'h6;
    chk("R7 address change ends conflict", 4'b1101);
    r_wr = 1'b0;
    chk("R11 read gives no write enable", 4'b1100);
    idle(); l_wr = 1'b1;
    chk("R11 deselected write gives no enable", 4'b1100);
    idle(); cyc();

    // R8: slave mode
    master_mode = 1'b0;
    l_sel_n = 1'b0; r_sel_n = 1'b0; l_addr = 4'h3; r_addr = 4'h3;
    l_wr = 1'b1; r_wr = 1'b1; l_busy_in_n = 1'b0;
    chk("R8 slave, left busy input low", 4'b1101);
    cyc();
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
    chk("R8 slave, right busy input low", 4'b1110);
    r_busy_in_n = 1'b1;
    chk("R8 slave, both inputs high", 4'b1111);
    idle(); cyc();

    // R9: master ignores busy inputs
    master_mode = 1'b1;
    l_sel_n = 1'b0; l_addr = 4'h8; l_wr = 1'b1; l_busy_in_n = 1'b0;
    r_busy_in_n = 1'b0;
    chk("R9 busy inputs ignored", 4'b1110);
    idle(); cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule